// File: doc/BRIEF.md
# Repeater-side jabber, collision and loopback controller

This block serves one transceiver port. It sits between the repeater-facing signals (transmit carrier and data coming in, receive data and a collision indication going out) and the twisted-pair side (line transmit enable and data going out, receive activity and data coming in). In normal mode it flags simultaneous transmit and receive activity on the collision output. It also locks out the line transmitter when the repeater keeps transmitting for too long, and it chooses whether the receive-data output echoes transmit data or carries line receive data.

The collision output is a square wave at half the clock rate, so a 20 MHz clock gives 10 MHz. While the output is inactive it rests low. The jabber and unjab windows are counted in ticks from a prescaler. By default the values give 30 ms and 350 ms at 20 MHz, and a testbench can shrink them. In full-duplex mode the block raises no collision, does no loopback and keeps the collision output low. Jabber lockout still applies in full-duplex mode and is reported on a status bit for the management port. Normal mode is active out of reset.

Top module: `jcl_port_ctrl`

## Requirements
- R1: After reset `jabber_o` and `pci_o` are 0, the mode follows `full_duplex_i` (0 = normal, 1 = full duplex), and with all inputs low `tx_en_o` and `pdi_o` are 0.
- R2: In normal mode, when `tx_en_o` and `rx_active_i` are both 1, `pci_o` is 1 on the first clock edge after, and it inverts on every edge while the condition holds. It is 0 on the first edge after the condition and jabber are both gone.
- R3: A collision changes nothing except `pci_o`: `tx_en_o` stays 1 and `tx_data_o` keeps following `pdo_data_i`.
- R4: `jabber_o` rises on the edge that completes `JAB_TICKS*PRESCALE` consecutive clock edges with `pdo_active_i` high. A burst that is one edge shorter leaves `jabber_o` at 0.
- R5: While `jabber_o` is 1, `tx_en_o` and `tx_data_o` are 0, `pdi_o` does not loop back `pdo_data_i`, and in normal mode `pci_o` toggles on every edge.
- R6: `jabber_o` falls on the edge that completes `UNJAB_TICKS*PRESCALE` consecutive edges with `pdo_active_i` low. In normal mode `pci_o` is 0 from the following edge onward.
- R7: If `pdo_active_i` is high on any edge during the unjab wait, the wait restarts from zero.
- R8: In normal mode, `pdi_o` equals `pdo_data_i` while `tx_en_o` is 1. Otherwise it equals `rx_data_i` while `rx_active_i` is 1, and it is 0 in all other cases.
- R9: In full-duplex mode `pci_o` stays 0 through collisions and jabber, `pdi_o` equals `rx_data_i` while `rx_active_i` is 1 (and is 0 otherwise) even while transmitting, and `jabber_o` still reports lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (20 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| full_duplex_i | input | 1 | 1 = full duplex, 0 = normal |
| pdo_active_i | input | 1 | Repeater transmit carrier present |
| pdo_data_i | input | 1 | Repeater transmit data |
| rx_active_i | input | 1 | Line receive activity |
| rx_data_i | input | 1 | Line receive data |
| tx_en_o | output | 1 | Line transmitter enable |
| tx_data_o | output | 1 | Line transmit data |
| pdi_o | output | 1 | Data returned to the repeater |
| pci_o | output | 1 | Collision/jabber square wave to the repeater |
| jabber_o | output | 1 | Jabber lockout status |

## Verification
`tx_en_o`, `tx_data_o` and `pdi_o` are combinational, so they are checked 1 ns after the inputs change at a falling edge. `jabber_o` changes on the rising edge that completes its window. It is sampled at the falling edge one cycle before that edge, where it must still hold its old value, and at the falling edge right after it. `pci_o` adds one more register, so it is checked one edge after the cause, alternating 1 and 0 on the edges that follow. The bench scales the windows to 12 edges for jabber and 20 edges for unjab, so every boundary falls on an exactly predicted edge.

// File: rtl/jcl_pkg.sv
package jcl_pkg;
  typedef enum logic {
    JS_OK   = 1'b0,
    JS_LOCK = 1'b1
  } jab_state_e;
endpackage

// File: rtl/jcl_tick_gen.sv
module jcl_tick_gen #(
  parameter int PRESCALE = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  generate
    if (PRESCALE <= 1) begin : g_direct
      assign tick_o = run_i;
    end else begin : g_count
      logic [CW-1:0] cnt_q;
      assign tick_o = run_i && (cnt_q == CW'(PRESCALE - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      cnt_q <= '0;
        else if (!run_i)  cnt_q <= '0;   // window restarts whenever run drops
        else if (tick_o)  cnt_q <= '0;
        else              cnt_q <= cnt_q + CW'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/jcl_jabber_fsm.sv
module jcl_jabber_fsm
  import jcl_pkg::*;
#(
  parameter int JAB_TICKS   = 30,
  parameter int UNJAB_TICKS = 350
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pdo_active_i,
  input  logic tick_i,
  output logic run_o,
  output logic jab_o
);
  localparam int AW = (JAB_TICKS > 1) ? $clog2(JAB_TICKS) : 1;
  localparam int QW = (UNJAB_TICKS > 1) ? $clog2(UNJAB_TICKS) : 1;

  jab_state_e    state_q;
  logic [AW-1:0] act_q;
  logic [QW-1:0] quiet_q;

  // timer runs on carrier while unlocked, on silence while locked
  assign run_o = (state_q == JS_OK) ? pdo_active_i : !pdo_active_i;
  assign jab_o = (state_q == JS_LOCK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= JS_OK;
      act_q   <= '0;
      quiet_q <= '0;
    end else begin
      case (state_q)
        JS_OK: begin
          quiet_q <= '0;
          if (!pdo_active_i) act_q <= '0;
          else if (tick_i) begin
            if (act_q == AW'(JAB_TICKS - 1)) begin
              state_q <= JS_LOCK;
              act_q   <= '0;
            end else act_q <= act_q + AW'(1);
          end
        end
        default: begin
          act_q <= '0;
          if (pdo_active_i) quiet_q <= '0;
          else if (tick_i) begin
            if (quiet_q == QW'(UNJAB_TICKS - 1)) begin
              state_q <= JS_OK;
              quiet_q <= '0;
            end else quiet_q <= quiet_q + QW'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/jcl_coll_pci.sv
module jcl_coll_pci (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic full_duplex_i,
  input  logic tx_en_i,
  input  logic rx_active_i,
  input  logic jab_i,
  output logic pci_o
);
  logic coll, pci_on, pci_q;

  assign coll   = !full_duplex_i && tx_en_i && rx_active_i;
  assign pci_on = !full_duplex_i && (coll || jab_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pci_q <= 1'b0;
    else if (pci_on) pci_q <= !pci_q;   // half-rate square wave
    else             pci_q <= 1'b0;
  end

  assign pci_o = pci_q;
endmodule

// File: rtl/jcl_pdi_mux.sv
module jcl_pdi_mux (
  input  logic full_duplex_i,
  input  logic tx_en_i,
  input  logic pdo_data_i,
  input  logic rx_active_i,
  input  logic rx_data_i,
  output logic pdi_o
);
  always_comb begin
    if (!full_duplex_i && tx_en_i) pdi_o = pdo_data_i;
    else if (rx_active_i)          pdi_o = rx_data_i;
    else                           pdi_o = 1'b0;
  end
endmodule

// File: rtl/jcl_port_ctrl.sv
module jcl_port_ctrl #(
  parameter int PRESCALE    = 20000,
  parameter int JAB_TICKS   = 30,
  parameter int UNJAB_TICKS = 350
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic full_duplex_i,
  input  logic pdo_active_i,
  input  logic pdo_data_i,
  input  logic rx_active_i,
  input  logic rx_data_i,
  output logic tx_en_o,
  output logic tx_data_o,
  output logic pdi_o,
  output logic pci_o,
  output logic jabber_o
);
  logic run, tick, jab;

  jcl_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(run), .tick_o(tick)
  );

  jcl_jabber_fsm #(.JAB_TICKS(JAB_TICKS), .UNJAB_TICKS(UNJAB_TICKS)) u_jab (
    .clk_i(clk_i), .rst_ni(rst_ni), .pdo_active_i(pdo_active_i),
    .tick_i(tick), .run_o(run), .jab_o(jab)
  );

  assign tx_en_o   = pdo_active_i && !jab;
  assign tx_data_o = tx_en_o && pdo_data_i;
  assign jabber_o  = jab;

  jcl_coll_pci u_pci (
    .clk_i(clk_i), .rst_ni(rst_ni), .full_duplex_i(full_duplex_i),
    .tx_en_i(tx_en_o), .rx_active_i(rx_active_i), .jab_i(jab), .pci_o(pci_o)
  );

  jcl_pdi_mux u_pdi (
    .full_duplex_i(full_duplex_i), .tx_en_i(tx_en_o), .pdo_data_i(pdo_data_i),
    .rx_active_i(rx_active_i), .rx_data_i(rx_data_i), .pdi_o(pdi_o)
  );
endmodule

// File: rtl/jcl_port_ctrl_chk.sv
module jcl_port_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic full_duplex_i,
  input logic pdo_active_i,
  input logic pdo_data_i,
  input logic rx_active_i,
  input logic tx_en_o,
  input logic tx_data_o,
  input logic pdi_o,
  input logic pci_o,
  input logic jabber_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  a_r2_pci_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    $past(!full_duplex_i && tx_en_o && rx_active_i) |-> (pci_o != $past(pci_o)));

  a_r6_pci_rests_low: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    $past(!jabber_o && !(tx_en_o && rx_active_i)) |-> !pci_o);

  a_r9_fd_pci_low: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    $past(full_duplex_i) |-> !pci_o);

  a_r4_jab_needs_carrier: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    $rose(jabber_o) |-> $past(pdo_active_i));

  a_r6_unjab_needs_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni || !past_ok)
    $fell(jabber_o) |-> !$past(pdo_active_i));

  a_r5_no_tx_in_jab: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jabber_o |-> (!tx_en_o && !tx_data_o));

  a_r8_loopback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_duplex_i && tx_en_o) |-> (pdi_o == pdo_data_i));

  a_r3_tx_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_o |-> (tx_data_o == pdo_data_i));
endmodule

bind jcl_port_ctrl jcl_port_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .full_duplex_i(full_duplex_i),
  .pdo_active_i(pdo_active_i), .pdo_data_i(pdo_data_i), .rx_active_i(rx_active_i),
  .tx_en_o(tx_en_o), .tx_data_o(tx_data_o), .pdi_o(pdi_o), .pci_o(pci_o),
  .jabber_o(jabber_o)
);

// File: tb/jcl_port_ctrl_tb_top.sv
module jcl_port_ctrl_tb_top;
  localparam int PRE = 4;
  localparam int JT  = 3;
  localparam int UT  = 5;
  localparam int N   = PRE * JT;   // edges to jabber
  localparam int M   = PRE * UT;   // edges to unjab

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic fd = 1'b0, pdo_act = 1'b0, pdo_dat = 1'b0, rx_act = 1'b0, rx_dat = 1'b0;
  logic tx_en, tx_dat, pdi, pci, jab;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  jcl_port_ctrl #(.PRESCALE(PRE), .JAB_TICKS(JT), .UNJAB_TICKS(UT)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .full_duplex_i(fd), .pdo_active_i(pdo_act),
    .pdo_data_i(pdo_dat), .rx_active_i(rx_act), .rx_data_i(rx_dat),
    .tx_en_o(tx_en), .tx_data_o(tx_dat), .pdi_o(pdi), .pci_o(pci), .jabber_o(jab)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1); #1;
    // R1 reset state
    chk("R1", "jabber", jab, 1'b0);
    chk("R1", "pci", pci, 1'b0);
    chk("R1", "tx_en", tx_en, 1'b0);
    chk("R1", "pdi", pdi, 1'b0);

    // R8 loopback and receive path, sweep of data values
    for (int v = 0; v < 4; v++) begin
      step(1);
      pdo_act = 1'b1; pdo_dat = v[0]; rx_act = 1'b0; rx_dat = v[1]; #1;
      chk("R8", "loop pdi", pdi, v[0]);
      chk("R3", "tx_data", tx_dat, v[0]);
      chk("R3", "tx_en", tx_en, 1'b1);
      step(1);
      pdo_act = 1'b0; rx_act = 1'b1; #1;
      chk("R8", "rx pdi", pdi, v[1]);
      chk("R8", "tx_en idle", tx_en, 1'b0);
      step(1);
      rx_act = 1'b0; #1;
      chk("R8", "idle pdi", pdi, 1'b0);
      chk("R2", "pci idle", pci, 1'b0);
    end

    // R2/R3 collision in normal mode
    step(1);
    rx_act = 1'b1; rx_dat = 1'b0; pdo_act = 1'b1; pdo_dat = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      step(1); #1;
      chk("R2", "pci toggle", pci, logic'(k % 2));
      chk("R3", "tx_en in coll", tx_en, 1'b1);
      pdo_dat = logic'(k % 2);
      #1 chk("R3", "tx_data in coll", tx_dat, logic'(k % 2));
    end
    step(1);
    rx_act = 1'b0; pdo_act = 1'b0;
    step(1); #1;
    chk("R2", "pci low after coll", pci, 1'b0);
    chk("R4", "no jab from coll", jab, 1'b0);

    // R4 burst one edge short
    step(2);
    pdo_act = 1'b1; pdo_dat = 1'b1;
    step(N - 1); #1;
    chk("R4", "short burst", jab, 1'b0);
    pdo_act = 1'b0;
    step(3); #1;
    chk("R4", "after short burst", jab, 1'b0);

    // R4/R5 full jabber
    pdo_act = 1'b1;
    step(N - 1); #1;
    chk("R4", "edge before jab", jab, 1'b0);
    chk("R5", "tx before jab", tx_en, 1'b1);
    step(1); #1;
    chk("R4", "jab declared", jab, 1'b1);
    chk("R5", "tx off", tx_en, 1'b0);
    chk("R5", "tx_data off", tx_dat, 1'b0);
    chk("R5", "no loopback", pdi, 1'b0);
    chk("R5", "pci not yet", pci, 1'b0);
    for (int k = 1; k <= 4; k++) begin
      step(1); #1;
      chk("R5", "pci jab toggle", pci, logic'(k % 2));
    end
    rx_act = 1'b1; rx_dat = 1'b1; #1;
    chk("R5", "pdi rx in jab", pdi, 1'b1);
    rx_act = 1'b0;

    // R7 restart during unjab, then R6 release
    pdo_act = 1'b0;
    step(M - 2); #1;
    chk("R7", "still jab", jab, 1'b1);
    pdo_act = 1'b1;
    step(1);
    pdo_act = 1'b0;
    step(M - 1); #1;
    chk("R7", "wait restarted", jab, 1'b1);
    step(1); #1;
    chk("R6", "unjab", jab, 1'b0);
    step(1); #1;
    chk("R6", "pci rests", pci, 1'b0);
    step(2); #1;
    chk("R6", "pci still low", pci, 1'b0);
    pdo_act = 1'b1; pdo_dat = 1'b1; #1;
    chk("R6", "tx restored", tx_en, 1'b1);
    pdo_act = 1'b0;

    // R9 full duplex
    step(2);
    fd = 1'b1; rx_act = 1'b1; rx_dat = 1'b1; pdo_act = 1'b1; pdo_dat = 1'b0; #1;
    chk("R9", "pdi rx while tx", pdi, 1'b1);
    chk("R9", "tx_en fd", tx_en, 1'b1);
    step(3); #1;
    chk("R9", "no coll pci", pci, 1'b0);
    step(N - 4); #1;
    chk("R9", "fd pre-jab", jab, 1'b0);
    step(1); #1;
    chk("R9", "fd jab reported", jab, 1'b1);
    chk("R9", "fd tx off", tx_en, 1'b0);
    step(2); #1;
    chk("R9", "fd pci low in jab", pci, 1'b0);
    pdo_act = 1'b0; rx_act = 1'b0;
    step(M); #1;
    chk("R9", "fd unjab", jab, 1'b0);
    chk("R9", "fd pdi idle", pdi, 1'b0);
    fd = 1'b0;
    step(2);
    finish_run();
  end
endmodule